// File: doc/BRIEF.md
# Bidirectional Double-Data-Rate Pad Register

This block sits between core logic and a group of bidirectional pads and moves two data words per clock period in each direction. On the transmit side, core logic presents a high-phase word, a low-phase word and an active-high drive enable on the rising edge of the transmit clock. The block registers all three and places the high word on the pads while that clock is high and the low word while it is low. The pads are released (high impedance) whenever the registered enable is off, and they stay released from reset until core logic asks for them.

On the receive side, the pads are sampled on both edges of an independent receive clock. Each rising edge hands core logic a matched pair: the value seen at that rising edge, and the value seen at the falling edge just before it. Each direction has its own clock enable. While an enable is low, that direction's registers keep their contents on both edges. The two sides share one asynchronous active-low reset and a single width parameter.

Pad traffic cannot be stalled, so the core-side buses carry no valid/ready handshake. A word pair moves on every enabled clock period, and the clock enables are the only means of pausing a direction.

Top module: `ddr_pad_io`

## Requirements
- R1: With `tx_ce` high, `tx_hi`, `tx_lo` and `tx_oe` are registered on the rising edge of `tx_clk`. Nothing on the pads changes in response to these inputs before that edge.
- R2: While the registered enable is on, the pads carry the registered high word during the high phase of `tx_clk` that follows the registering edge, and the registered low word during the low phase that comes next.
- R3: `tx_oe` is active-high: 1 makes the block drive the pads, and 0 releases them so that another driver can set their level.
- R4: From reset until a 1 on `tx_oe` has been registered, the block does not drive the pads.
- R5: The drive enable changes only on rising edges of `tx_clk`. During a low phase, the block drives (or releases) the pads according to the enable registered at the rising edge just before it.
- R6: On each rising edge of `rx_clk` with `rx_ce` high, `rx_hi` takes the pad value at that edge and `rx_lo` takes the pad value at the falling edge immediately before it. Both outputs update together.
- R7: While `tx_ce` is low, the transmit registers hold their values on both edges, so the pads keep repeating the previous high/low pattern and the previous enable.
- R8: While `rx_ce` is low, the receive registers hold their values on both edges. If the falling edge was skipped, the next enabled rising edge pairs the new high sample with the low sample held from the earlier falling edge.
- R9: Reset clears `rx_hi` and `rx_lo` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both directions |
| tx_clk | input | 1 | Transmit clock |
| tx_ce | input | 1 | Transmit clock enable |
| tx_oe | input | 1 | Active-high pad drive enable |
| tx_hi | input | WIDTH | Word driven during the high phase of `tx_clk` |
| tx_lo | input | WIDTH | Word driven during the low phase of `tx_clk` |
| rx_clk | input | 1 | Receive clock |
| rx_ce | input | 1 | Receive clock enable |
| rx_hi | output | WIDTH | Pad value captured at the latest rising edge |
| rx_lo | output | WIDTH | Pad value captured at the falling edge before it |
| pad | inout | WIDTH | Bidirectional pad bus |

## Verification
The hardest case to reach is a skipped falling edge. The receive enable has to drop across exactly one falling edge and come back before the following rising edge, so that the new high sample is paired with a stale low sample. The bench reaches it by switching `rx_ce` a quarter period after each edge while its pad model changes level at the opposite quarter points. The other hard case is the handover of the pads: the bench's pad model drives only in periods its own enable model says are released. Captured words that match the model's levels therefore show that the block let go of the bus at the right rising edge and not at the falling edge before it.

// File: rtl/ddr_pad_pkg.sv
`timescale 1ns/1ps
package ddr_pad_pkg;
  // Pad driver control as seen by the output buffer: low means drive.
  typedef enum logic {
    DRV_ON  = 1'b0,
    DRV_OFF = 1'b1
  } drv_ctl_e;

  function automatic drv_ctl_e to_drv_ctl(input logic enable_hi);
    return enable_hi ? DRV_ON : DRV_OFF;
  endfunction
endpackage

// File: rtl/ddr_launch.sv
`timescale 1ns/1ps
module ddr_launch
  import ddr_pad_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             oe_in,
  input  logic [WIDTH-1:0] hi_in,
  input  logic [WIDTH-1:0] lo_in,
  output logic [WIDTH-1:0] pad_val,
  output drv_ctl_e         drv_ctl
);
  logic [WIDTH-1:0] hi_q;
  logic [WIDTH-1:0] lo_q;
  logic [WIDTH-1:0] lo_fall_q;
  drv_ctl_e         drv_q;

  // Rising-edge launch registers: data and inverted enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      drv_q <= DRV_OFF;
    end else if (ce) begin
      hi_q  <= hi_in;
      lo_q  <= lo_in;
      drv_q <= to_drv_ctl(oe_in);
    end
  end

  // Falling-edge retime of the low word so it appears half a period later.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_fall_q <= '0;
    end else if (ce) begin
      lo_fall_q <= lo_q;
    end
  end

  // Phase select: high word while the clock is high, low word otherwise.
  always_comb begin
    pad_val = clk ? hi_q : lo_fall_q;
  end

  assign drv_ctl = drv_q;

  // Checker flop: enable seen during the low phase.
  drv_ctl_e drv_at_fall;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) drv_at_fall <= DRV_OFF;
    else        drv_at_fall <= drv_q;
  end

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(hi_q) && $stable(lo_q) && $stable(drv_q)));

  a_r4_off_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (drv_q == DRV_OFF));

  a_r5_enable_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (drv_at_fall == drv_q));
endmodule

// File: rtl/ddr_capture.sv
`timescale 1ns/1ps
module ddr_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] hi_out,
  output logic [WIDTH-1:0] lo_out
);
  logic [WIDTH-1:0] fall_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)  fall_q <= '0;
    else if (ce) fall_q <= pad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_out <= '0;
      lo_out <= '0;
    end else if (ce) begin
      hi_out <= pad_in;
      lo_out <= fall_q;
    end
  end

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(hi_out) && $stable(lo_out)));
endmodule

// File: rtl/ddr_pad_drv.sv
`timescale 1ns/1ps
module ddr_pad_drv
  import ddr_pad_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  drv_ctl_e         drv_ctl,
  input  logic [WIDTH-1:0] val,
  inout  wire  [WIDTH-1:0] pad
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pad[i] = (drv_ctl == DRV_ON) ? val[i] : 1'bz;
  end
endmodule

// File: rtl/ddr_pad_io.sv
`timescale 1ns/1ps
module ddr_pad_io
  import ddr_pad_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             rst_n,
  input  logic             tx_clk,
  input  logic             tx_ce,
  input  logic             tx_oe,
  input  logic [WIDTH-1:0] tx_hi,
  input  logic [WIDTH-1:0] tx_lo,
  input  logic             rx_clk,
  input  logic             rx_ce,
  output logic [WIDTH-1:0] rx_hi,
  output logic [WIDTH-1:0] rx_lo,
  inout  wire  [WIDTH-1:0] pad
);
  logic [WIDTH-1:0] launch_val;
  drv_ctl_e         launch_ctl;

  ddr_launch #(.WIDTH(WIDTH)) u_launch (
    .clk     (tx_clk),
    .rst_n   (rst_n),
    .ce      (tx_ce),
    .oe_in   (tx_oe),
    .hi_in   (tx_hi),
    .lo_in   (tx_lo),
    .pad_val (launch_val),
    .drv_ctl (launch_ctl)
  );

  ddr_pad_drv #(.WIDTH(WIDTH)) u_drv (
    .drv_ctl (launch_ctl),
    .val     (launch_val),
    .pad     (pad)
  );

  ddr_capture #(.WIDTH(WIDTH)) u_capture (
    .clk    (rx_clk),
    .rst_n  (rst_n),
    .ce     (rx_ce),
    .pad_in (pad),
    .hi_out (rx_hi),
    .lo_out (rx_lo)
  );
endmodule

// File: tb/ddr_pad_io_bench.sv
`timescale 1ns/1ps
module ddr_pad_io_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tx_ce = 1'b0, tx_oe = 1'b0, rx_ce = 1'b0;
  logic [W-1:0] tx_hi = '0, tx_lo = '0;
  logic [W-1:0] rx_hi, rx_lo;
  wire  [W-1:0] pad;
  logic         mdl_drive = 1'b0;
  logic [W-1:0] mdl_val = '0;
  int           checks = 0, failures = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  assign pad = mdl_drive ? mdl_val : {W{1'bz}};

  ddr_pad_io #(.WIDTH(W)) u_ddr_pad_io (
    .rst_n (rst_n), .tx_clk (clk), .tx_ce (tx_ce), .tx_oe (tx_oe),
    .tx_hi (tx_hi), .tx_lo (tx_lo), .rx_clk (clk), .rx_ce (rx_ce),
    .rx_hi (rx_hi), .rx_lo (rx_lo), .pad (pad)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Set transmit inputs just after a falling edge; they register at the next rising edge.
  task automatic set_tx(input logic [W-1:0] h, input logic [W-1:0] l, input logic oe, input logic ce);
    @(negedge clk); #1;
    tx_hi = h; tx_lo = l; tx_oe = oe; tx_ce = ce;
  endtask

  // Model drives low sample before the falling edge, high sample before the rising edge.
  task automatic rx_pair(input logic [W-1:0] l, input logic [W-1:0] h, input string req);
    @(posedge clk); #1.25 mdl_val = l;
    @(negedge clk); #1.25 mdl_val = h;
    @(posedge clk); #1;
    check({req, " rx_hi"}, rx_hi, h);
    check({req, " rx_lo"}, rx_lo, l);
  endtask

  task automatic t_reset;
    rx_ce = 1'b1; tx_ce = 1'b1; tx_oe = 1'b0;
    mdl_drive = 1'b1; mdl_val = 8'h5A;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset rx_hi", rx_hi, '0);
    check("R9 reset rx_lo", rx_lo, '0);
    @(negedge clk); rst_n = 1'b1;
    // Released since reset: model levels come back through capture (R4).
    rx_pair(8'h3C, 8'hC3, "R4");
  endtask

  task automatic t_capture;
    rx_pair(8'h11, 8'hEE, "R6 a");
    rx_pair(8'hF0, 8'h0F, "R6 b");
  endtask

  task automatic t_launch(input logic [W-1:0] h, input logic [W-1:0] l);
    mdl_drive = 1'b0;
    set_tx(h, l, 1'b1, 1'b1);
    @(posedge clk); #1.25 check("R1 R2 R3 high phase", pad, h);
    @(negedge clk); #1.25 check("R2 low phase", pad, l);
  endtask

  task automatic t_tx_hold;
    set_tx(8'h99, 8'h66, 1'b1, 1'b0);
    @(posedge clk); #1.25 check("R7 high held", pad, 8'hA5);
    @(negedge clk); #1.25 check("R7 low held", pad, 8'h5A);
    @(posedge clk); #1.25 check("R7 high held again", pad, 8'hA5);
  endtask

  task automatic t_release;
    set_tx(8'h81, 8'h18, 1'b1, 1'b1);
    @(posedge clk); #1.25 check("R5 high phase", pad, 8'h81);
    @(negedge clk); #1 tx_oe = 1'b0;
    #0.25 check("R5 low phase still driven", pad, 8'h18);
    @(posedge clk); #1.25 mdl_drive = 1'b1; mdl_val = 8'h00;
    rx_pair(8'h24, 8'h42, "R3 R5 released");
  endtask

  task automatic t_rx_hold;
    rx_pair(8'h12, 8'h34, "R8 setup");
    #0.25 rx_ce = 1'b0;
    mdl_val = 8'hAA;
    @(negedge clk); #1.25 mdl_val = 8'hBB;
    @(posedge clk); #1;
    check("R8 rx_hi held", rx_hi, 8'h34);
    check("R8 rx_lo held", rx_lo, 8'h12);
    // Skip the falling edge, enable only for the rising edge.
    #0.25 mdl_val = 8'hCC;
    @(negedge clk); #1.25 mdl_val = 8'hDD; rx_ce = 1'b1;
    @(posedge clk); #1;
    check("R8 new high", rx_hi, 8'hDD);
    check("R8 stale low", rx_lo, 8'h12);
  endtask

  initial begin
    t_reset();
    t_capture();
    t_launch(8'hA5, 8'h5A);
    t_tx_hold();
    t_launch(8'hC0, 8'h0C);
    t_release();
    t_rx_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule